// File: doc/BRIEF.md
# Buffered Output Compare Channel

This block is one compare channel of a general-purpose timer. It watches a free-running 16-bit count that arrives from outside. When the channel is enabled and the count equals the channel's active compare value, the channel updates a registered output pin. A 3-bit mode selects whether that update sets the pin, clears it, toggles it, or leaves it as it is. Each match also sets a sticky interrupt flag. A mask input gates that flag onto the interrupt request line.

Software writes the compare value one byte at a time. A low-byte write only fills a holding register. The high-byte write joins the new high byte with the held low byte. In the three simple modes (set, clear, toggle) the joined value becomes active on the next clock. In every other mode it waits in a pending register until the running count next reads zero. If another high-byte write arrives before then, it replaces the pending value.

Top module: `ocmp_channel`

## Requirements
- R1: After synchronous reset, `pin_out`, `irq_flag` and `irq_req` are 0 and `cmp_active` is 0x0000.
- R2: A `wr_lo` strobe alone stores `wr_data` as the low byte and leaves `cmp_active` unchanged.
- R3: With `mode` 0, 1 or 2, a `wr_hi` strobe loads `cmp_active` with {`wr_data`, last stored low byte}, visible after the next clock edge.
- R4: With `mode` 3 to 7, a `wr_hi` strobe leaves `cmp_active` unchanged and parks the joined value. The parked value moves into `cmp_active` on the first clock edge at which `run` is 1 and `count` is 0x0000.
- R5: A second `wr_hi` in modes 3 to 7, made before the parked value is applied, replaces the parked value. Only the latest value reaches `cmp_active`.
- R6: While `run` is 0, an equal `count` produces no match: the pin holds and the flag stays clear.
- R7: On a match (`run` is 1 and `count` equals `cmp_active`), the edge that samples the match sets `pin_out` to 1 when `mode` is 0, to 0 when `mode` is 1, and inverts it when `mode` is 2.
- R8: With `mode` 3 to 7, a match leaves `pin_out` unchanged.
- R9: Every match sets `irq_flag` on the edge that samples it. The flag stays set until a `flag_clr` strobe, and a match in the same cycle as `flag_clr` keeps it set.
- R10: `irq_req` is 1 exactly when `irq_flag` and `irq_mask` are both 1.
- R11: `pin_out` comes straight from a flip-flop and changes only on the edge after a cycle with a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Timer started; enables matching and the deferred load |
| count | input | 16 | Running counter value |
| wr_lo | input | 1 | Low-byte write strobe |
| wr_hi | input | 1 | High-byte write strobe |
| wr_data | input | 8 | Write data byte |
| mode | input | 3 | Compare action: 0 set, 1 clear, 2 toggle, 3-7 hold |
| irq_mask | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| cmp_active | output | 16 | Compare value currently in use |
| pin_out | output | 1 | Registered compare output |
| irq_flag | output | 1 | Sticky match flag |
| irq_req | output | 1 | Masked interrupt request |

## Verification
A wrong low-byte holding register or pending register stays hidden until the next high-byte write or the next zero count. It then shows up on `cmp_active` on the following edge, so each check places its write and its zero count only a cycle or two before it samples. A wrong active value or a wrong mode decode shows up one edge after the intended match count: the pin and the flag either move or fail to move. The tests therefore present matching and non-matching counts next to each other, in every mode class. A flag that is lost or wrongly retained shows on `irq_flag` and `irq_req` within one cycle of a clear strobe.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int BYTE_W_DEF = 8;
    localparam int MODE_W     = 3;

    localparam logic [MODE_W-1:0] MODE_SET = 3'd0;
    localparam logic [MODE_W-1:0] MODE_CLR = 3'd1;
    localparam logic [MODE_W-1:0] MODE_TGL = 3'd2;

    // How a high-byte write is applied to the compare value
    typedef enum logic [1:0] {
        LOAD_NONE = 2'd0,
        LOAD_NOW  = 2'd1,
        LOAD_PEND = 2'd2
    } load_e;

    // Modes whose new value takes effect at once
    function automatic logic mode_is_immediate(input logic [MODE_W-1:0] m);
        return (m <= MODE_TGL);
    endfunction

    // Next pin level after a match
    function automatic logic out_next(input logic [MODE_W-1:0] m, input logic cur);
        case (m)
            MODE_SET: return 1'b1;
            MODE_CLR: return 1'b0;
            MODE_TGL: return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/ocmp_value_regs.sv
module ocmp_value_regs
    import ocmp_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CNT_W-1:0]  count,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [MODE_W-1:0] mode,
    output logic [CNT_W-1:0]  active
);

    logic [BYTE_W-1:0] lo_q;
    logic [CNT_W-1:0]  pend_q;
    logic              pend_v_q;
    logic [CNT_W-1:0]  act_q;
    logic [CNT_W-1:0]  joined;
    logic              at_zero;
    load_e             ld;

    assign joined  = {wr_data, lo_q};
    assign at_zero = run && (count == '0) && pend_v_q;

    always_comb begin
        ld = LOAD_NONE;
        if (wr_hi) ld = mode_is_immediate(mode) ? LOAD_NOW : LOAD_PEND;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q     <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            act_q    <= '0;
        end else begin
            if (wr_lo) lo_q <= wr_data;
            case (ld)
                LOAD_NOW: begin
                    act_q    <= joined;
                    pend_v_q <= 1'b0;
                end
                LOAD_PEND: begin
                    pend_q   <= joined;
                    pend_v_q <= 1'b1;
                end
                default: begin
                    if (at_zero) begin
                        act_q    <= pend_q;
                        pend_v_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign active = act_q;

    // R2: a low-byte write alone never moves the active value
    p_lo_buffered_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi && !pend_v_q) |=> $stable(act_q));

    // R3: immediate modes load the joined value
    p_imm_load_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && mode <= 3'd2) |=> (act_q == {$past(wr_data), $past(lo_q)}));

    // R4: deferred modes keep the active value on the write edge
    p_defer_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && mode > 3'd2 && !(run && count == '0 && pend_v_q)) |=> $stable(act_q));

    // R5: a parked value is always pending after a deferred write
    p_pend_set_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && mode > 3'd2) |=> pend_v_q);

endmodule

// File: rtl/ocmp_out_ctrl.sv
module ocmp_out_ctrl
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 2 * BYTE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  active,
    input  logic [MODE_W-1:0] mode,
    output logic              hit,
    output logic              pin
);

    logic pin_q;

    assign hit = run && (count == active);

    always_ff @(posedge clk) begin
        if (rst)      pin_q <= 1'b0;
        else if (hit) pin_q <= out_next(mode, pin_q);
    end

    assign pin = pin_q;

    // R7: set and clear act on the match edge
    p_set_r7: assert property (@(posedge clk) disable iff (rst)
        (run && count == active && mode == 3'd0) |=> pin_q);
    p_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (run && count == active && mode == 3'd1) |=> !pin_q);
    p_tgl_r7: assert property (@(posedge clk) disable iff (rst)
        (run && count == active && mode == 3'd2) |=> (pin_q != $past(pin_q)));

    // R8 / R6 / R11: no change without an action-bearing match
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mode > 3'd2) |=> $stable(pin_q));
    p_no_match_r11: assert property (@(posedge clk) disable iff (rst)
        !(run && count == active) |=> $stable(pin_q));

endmodule

// File: rtl/ocmp_irq_flag.sv
module ocmp_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    input  logic mask,
    output logic flag,
    output logic req
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign req  = flag_q & mask;

    // R9: match sets the flag, even against a clear
    p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CNT_W-1:0]  count,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [MODE_W-1:0] mode,
    input  logic              irq_mask,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  cmp_active,
    output logic              pin_out,
    output logic              irq_flag,
    output logic              irq_req
);

    logic hit;

    ocmp_value_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst(rst), .run(run), .count(count),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .mode(mode),
        .active(cmp_active)
    );

    ocmp_out_ctrl #(.CNT_W(CNT_W)) u_out (
        .clk(clk), .rst(rst), .run(run), .count(count),
        .active(cmp_active), .mode(mode), .hit(hit), .pin(pin_out)
    );

    ocmp_irq_flag u_irq (
        .clk(clk), .rst(rst), .hit(hit), .clr(flag_clr), .mask(irq_mask),
        .flag(irq_flag), .req(irq_req)
    );

    // R6: a stopped timer never raises a fresh flag
    p_stopped_r6: assert property (@(posedge clk) disable iff (rst)
        (!run && !irq_flag) |=> !irq_flag);

    // R10: request only with the mask set
    p_req_mask_r10: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_flag && irq_mask));

endmodule

// File: tb/ocmp_channel_tb.sv
module ocmp_channel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        run;
    logic [15:0] count;
    logic        wr_lo, wr_hi;
    logic [7:0]  wr_data;
    logic [2:0]  mode;
    logic        irq_mask, flag_clr;
    logic [15:0] cmp_active;
    logic        pin_out, irq_flag, irq_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    ocmp_channel u_dut (
        .clk(clk), .rst(rst), .run(run), .count(count),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .mode(mode),
        .irq_mask(irq_mask), .flag_clr(flag_clr),
        .cmp_active(cmp_active), .pin_out(pin_out),
        .irq_flag(irq_flag), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one clock: inputs already set at a falling edge, sample at the next
    task automatic tick();
        @(negedge clk);
        wr_lo = 0; wr_hi = 0; flag_clr = 0;
    endtask

    task automatic t_reset();
        rst = 1; run = 0; count = 16'h5555; wr_lo = 0; wr_hi = 0;
        wr_data = 0; mode = 0; irq_mask = 0; flag_clr = 0;
        tick(); tick();
        rst = 0;
        tick();
        chk("R1 active", cmp_active, 16'h0000);
        chk("R1 pin", {15'd0, pin_out}, 16'd0);
        chk("R1 flag", {15'd0, irq_flag}, 16'd0);
        chk("R1 req", {15'd0, irq_req}, 16'd0);
    endtask

    task automatic t_immediate_write();
        mode = 3'd0;
        wr_lo = 1; wr_data = 8'h34; tick();
        chk("R2 lo only", cmp_active, 16'h0000);
        wr_hi = 1; wr_data = 8'h12; tick();
        chk("R3 joined", cmp_active, 16'h1234);
    endtask

    task automatic t_actions();
        run = 1; count = 16'h1233; mode = 3'd0; tick();
        chk("R11 no match", {15'd0, pin_out}, 16'd0);
        chk("R9 no flag", {15'd0, irq_flag}, 16'd0);
        count = 16'h1234; tick();
        chk("R7 set", {15'd0, pin_out}, 16'd1);
        chk("R9 flag", {15'd0, irq_flag}, 16'd1);
        mode = 3'd1; tick();
        chk("R7 clear", {15'd0, pin_out}, 16'd0);
        mode = 3'd2; tick();
        chk("R7 toggle up", {15'd0, pin_out}, 16'd1);
        tick();
        chk("R7 toggle down", {15'd0, pin_out}, 16'd0);
        count = 16'h0001; flag_clr = 1; tick();
        chk("R9 cleared", {15'd0, irq_flag}, 16'd0);
        run = 0; count = 16'h1234; tick();
        chk("R6 pin", {15'd0, pin_out}, 16'd0);
        chk("R6 flag", {15'd0, irq_flag}, 16'd0);
        run = 1; mode = 3'd0; flag_clr = 1; tick();
        chk("R9 set wins", {15'd0, irq_flag}, 16'd1);
        count = 16'h0002; tick(); tick();
        chk("R9 sticky", {15'd0, irq_flag}, 16'd1);
        chk("R10 masked", {15'd0, irq_req}, 16'd0);
        irq_mask = 1; #1;
        chk("R10 unmasked", {15'd0, irq_req}, 16'd1);
        irq_mask = 0;
    endtask

    task automatic t_hold_modes();
        for (int m = 3; m < 8; m++) begin
            mode = 3'(m); count = 16'h1234; tick();
            chk("R8 hold high", {15'd0, pin_out}, 16'd1);
            count = 16'h0003; tick();
        end
        mode = 3'd1; count = 16'h1234; tick();
        count = 16'h0003; tick();
        mode = 3'd6; count = 16'h1234; tick();
        chk("R8 hold low", {15'd0, pin_out}, 16'd0);
    endtask

    task automatic t_deferred();
        mode = 3'd4; count = 16'h0100; run = 1;
        wr_lo = 1; wr_data = 8'hCD; tick();
        wr_hi = 1; wr_data = 8'hAB; tick();
        chk("R4 not yet", cmp_active, 16'h1234);
        wr_lo = 1; wr_data = 8'hEF; tick();
        wr_hi = 1; wr_data = 8'h00; tick();
        chk("R5 still old", cmp_active, 16'h1234);
        run = 0; count = 16'h0000; tick();
        chk("R4 stopped zero", cmp_active, 16'h1234);
        run = 1; tick();
        chk("R5 latest applied", cmp_active, 16'h00EF);
        count = 16'h0005; tick();
        chk("R4 applied once", cmp_active, 16'h00EF);
    endtask

    initial begin
        t_reset();
        t_immediate_write();
        t_actions();
        t_hold_modes();
        t_deferred();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule